// File: doc/BRIEF.md
# Bus-Mapped Serial Transmit Channel

This block sits on a simple word-wide register port and turns bytes written by software into asynchronous serial frames on a single output line. Each byte written to the data register enters an eight-entry queue. A shift engine takes bytes from the queue one at a time and sends each one as a frame: a low start bit, eight data bits with the least significant bit first, and then one or two high stop bits. The bit period is set by a 16-bit divider. The line rests high whenever nothing is being sent.

Software checks the full flag in bit 31 of the data register before each write. It can also let a watermark interrupt tell it when the queue has drained below a chosen level. The control register enables the engine, selects the stop-bit count and holds the 3-bit watermark. Divider and stop-bit selection are captured at the start of each frame, so changing them never corrupts a frame that is already being sent. Clearing the enable lets the current frame finish and keeps all queued bytes.

The shift engine has four states. TX_IDLE holds the line high. It moves to TX_START when the engine is enabled and the queue holds a byte; that byte is popped at the same moment. TX_START drives the line low for one bit period and then moves to TX_DATA. TX_DATA sends eight bits and then moves to TX_STOP. TX_STOP drives the line high for one or two bit periods. From there it goes straight back to TX_START when the engine is enabled and a byte is waiting. Otherwise it returns to TX_IDLE.

Top module: `uart_tx_mm`

## Requirements
- R1: After reset, txd is 1 and irq is 0. Offsets 0x00, 0x08, 0x10 and 0x14 read 0, and offset 0x18 reads the divider reset value 138.
- R2: A write to offset 0x00 queues bits 7:0 of the write data. A read of offset 0x00 always returns 0 in bits 30:0.
- R3: The queue holds 8 bytes. Bit 31 of offset 0x00 reads 1 exactly while 8 bytes are held. A write to offset 0x00 while the queue is full is discarded and never sent.
- R4: Each frame is one start bit at 0, then eight data bits with the least significant bit first, then a stop bit at 1. Each bit lasts (D+1) clock cycles, where D is bits 15:0 of offset 0x18.
- R5: Offset 0x08 bit 0 enables transmission. While it is 0 and no frame is in progress, txd stays 1 and queued bytes are kept. They are sent once the bit is set.
- R6: Offset 0x08 bit 1 selects the stop-bit count: 0 gives one stop bit and 1 gives two stop bits.
- R7: Offset 0x08 bits 18:16 hold a watermark W. Offset 0x14 bit 0 reads 1 exactly while the queue occupancy is below W. Writes to offset 0x14 have no effect.
- R8: Offset 0x10 bit 0 is the watermark interrupt enable. irq equals that enable ANDed with offset 0x14 bit 0.
- R9: While the engine is enabled and bytes are waiting, each frame starts right after the last stop bit of the previous one. Start-bit edges are then (9+S)*(D+1) cycles apart, where S is the stop-bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_valid is 1 |
| bus_ready | output | 1 | Access accepted (always in the same cycle) |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Watermark interrupt |

## Verification
The bench fills the queue while the engine is disabled and then writes a ninth byte. A design that accepted or overwrote that byte would send a frame the scoreboard does not expect, or would send the wrong first byte. It sends back-to-back bursts with both stop-bit settings and with two divider values, checking every start-bit spacing. A design that inserted an idle gap or sent only one stop bit would move an edge off its expected cycle, and the second-stop sample would read the next frame's start bit as low. It also steps the occupancy across the watermark and writes to the read-only pending register. Either a comparison with the wrong sense or a writable pending bit would show up on offset 0x14 and on irq.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    localparam int BUS_W      = 32;
    localparam int OFF_TXDATA = 'h00;
    localparam int OFF_TXCTRL = 'h08;
    localparam int OFF_IE     = 'h10;
    localparam int OFF_IP     = 'h14;
    localparam int OFF_DIV    = 'h18;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             wr_ok, rd_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign wr_ok   = wr_req && !full;
    assign rd_ok   = rd_req && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_ok)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 16,
    parameter int WM_W      = 3,
    parameter int CNT_W     = 4,
    parameter int DIV_RESET = 138
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              fifo_full,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              push_req,
    output logic [DATA_W-1:0] push_data,
    output logic              tx_en,
    output logic              two_stop,
    output logic [WM_W-1:0]   wm_level,
    output logic              ie_tx,
    output logic              ip_tx,
    output logic [DIV_W-1:0]  divisor
);
    logic wr;
    logic unused_wdata;

    assign wr        = bus_valid && bus_we;
    assign push_req  = wr && (bus_addr == ADDR_W'(OFF_TXDATA));
    assign push_data = bus_wdata[DATA_W-1:0];
    assign ip_tx     = (fifo_count < CNT_W'(wm_level));
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            two_stop <= 1'b0;
            wm_level <= '0;
            ie_tx    <= 1'b0;
            divisor  <= DIV_W'(DIV_RESET);
        end else if (wr) begin
            if (bus_addr == ADDR_W'(OFF_TXCTRL)) begin
                tx_en    <= bus_wdata[0];
                two_stop <= bus_wdata[1];
                wm_level <= bus_wdata[16 +: WM_W];
            end
            if (bus_addr == ADDR_W'(OFF_IE))
                ie_tx <= bus_wdata[0];
            if (bus_addr == ADDR_W'(OFF_DIV))
                divisor <= bus_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_TXDATA))
            bus_rdata[BUS_W-1] = fifo_full;
        else if (bus_addr == ADDR_W'(OFF_TXCTRL)) begin
            bus_rdata[0]           = tx_en;
            bus_rdata[1]           = two_stop;
            bus_rdata[16 +: WM_W]  = wm_level;
        end else if (bus_addr == ADDR_W'(OFF_IE))
            bus_rdata[0] = ie_tx;
        else if (bus_addr == ADDR_W'(OFF_IP))
            bus_rdata[0] = ip_tx;
        else if (bus_addr == ADDR_W'(OFF_DIV))
            bus_rdata[DIV_W-1:0] = divisor;
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              two_stop,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    tx_state_t         state, nxt;
    logic [DIV_W-1:0]  baud_cnt, div_lat;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic              stop_idx, two_lat;
    logic              bit_end, have_byte, load;

    assign bit_end   = (baud_cnt == div_lat);
    assign have_byte = tx_en && !fifo_empty;
    assign load      = (nxt == TX_START) && (state != TX_START);
    assign pop       = load;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (have_byte) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bit_idx == IDX_W'(DATA_W - 1)) nxt = TX_STOP;
            TX_STOP:  if (bit_end && stop_idx == two_lat)
                          nxt = have_byte ? TX_START : TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_cnt <= '0;
            div_lat  <= '0;
            shreg    <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            two_lat  <= 1'b0;
        end else if (load) begin
            shreg    <= fifo_data;
            div_lat  <= divisor;
            two_lat  <= two_stop;
            baud_cnt <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
        end else if (state != TX_IDLE) begin
            if (bit_end) begin
                baud_cnt <= '0;
                if (state == TX_DATA) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 1'b1;
                end
                if (state == TX_STOP) stop_idx <= 1'b1;
            end else begin
                baud_cnt <= baud_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        busy = (state != TX_IDLE);
        unique case (state)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_mm.sv
module uart_tx_mm
    import uart_tx_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 16,
    parameter int WM_W       = 3,
    parameter int DIV_RESET  = 138
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              txd,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic              push_req, pop, fifo_full, fifo_empty;
    logic [DATA_W-1:0] push_data, fifo_data;
    logic [CNT_W-1:0]  fifo_count;
    logic              tx_en, two_stop, ie_tx, ip_tx, busy;
    logic [WM_W-1:0]   wm_level;
    logic [DIV_W-1:0]  divisor;

    assign bus_ready = bus_valid;
    assign irq       = ie_tx && ip_tx;

    uart_tx_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
        .WM_W(WM_W), .CNT_W(CNT_W), .DIV_RESET(DIV_RESET)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_full(fifo_full), .fifo_count(fifo_count),
        .push_req(push_req), .push_data(push_data),
        .tx_en(tx_en), .two_stop(two_stop), .wm_level(wm_level),
        .ie_tx(ie_tx), .ip_tx(ip_tx), .divisor(divisor)
    );

    uart_tx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .wr_req(push_req), .wr_data(push_data),
        .rd_req(pop), .rd_data(fifo_data),
        .full(fifo_full), .empty(fifo_empty), .count(fifo_count)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) shift_i (
        .clk(clk), .rst_n(rst_n),
        .tx_en(tx_en), .two_stop(two_stop), .divisor(divisor),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .pop(pop), .txd(txd), .busy(busy)
    );
endmodule

// File: rtl/uart_tx_mm_chk.sv
module uart_tx_mm_chk #(
    parameter int CNT_W = 4,
    parameter int DEPTH = 8,
    parameter int WM_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             irq,
    input logic             busy,
    input logic             tx_en,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic             pop,
    input logic [CNT_W-1:0] fifo_count,
    input logic [WM_W-1:0]  wm_level
);
    // R3
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop) |=> (fifo_count == $past(fifo_count)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_en) |=> (!busy && txd));

    // R9
    pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (!fifo_empty && tx_en));

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fifo_count < CNT_W'(wm_level)));
endmodule

bind uart_tx_mm uart_tx_mm_chk #(
    .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .WM_W(WM_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .txd(txd), .irq(irq), .busy(busy),
    .tx_en(tx_en), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .pop(pop), .fifo_count(fifo_count), .wm_level(wm_level)
);

// File: tb/uart_tx_mm_tb_top.sv
`timescale 1ns/1ps
module uart_tx_mm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, txd, irq;

    int tests = 0, fails = 0;
    int cyc = 0;
    int bitlen = 4;
    int nstop = 1;
    int frames = 0;
    int last_st = -1;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_mm dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .txd(txd), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit accept);
        bus_write(5'h00, {24'h0, b});
        if (accept) exp_q.push_back(b);
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        bus_read(a, v);
        check(v == e, req, v, e);
    endtask

    // Monitor: decodes frames at bit centres, compares against the queue.
    initial begin
        logic prev;
        logic [7:0] got;
        int st;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && !txd && prev) begin
                st = cyc;
                if (last_st >= 0)
                    check(st - last_st == (9 + nstop) * bitlen, "R9 start spacing",
                          st - last_st, (9 + nstop) * bitlen);
                last_st = st;
                repeat (bitlen / 2) @(negedge clk);
                check(txd == 1'b0, "R4 start bit", txd, 0);
                for (int j = 0; j < 8; j++) begin
                    repeat (bitlen) @(negedge clk);
                    got[j] = txd;
                end
                repeat (bitlen) @(negedge clk);
                check(txd == 1'b1, "R4 stop bit", txd, 1);
                if (nstop == 2) begin
                    repeat (bitlen) @(negedge clk);
                    check(txd == 1'b1, "R6 second stop bit", txd, 1);
                end
                frames++;
                if (exp_q.size() == 0)
                    check(1'b0, "R3 unexpected frame", got, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(got == e, "R4 frame data", got, e);
                end
                prev = txd;
            end else begin
                prev = txd;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int f0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(irq == 1'b0, "R1 irq", irq, 0);
        expect_reg(5'h00, 32'h0, "R1 data reg");
        expect_reg(5'h08, 32'h0, "R1 ctrl reg");
        expect_reg(5'h10, 32'h0, "R1 ie reg");
        expect_reg(5'h14, 32'h0, "R1 ip reg");
        expect_reg(5'h18, 32'd138, "R1 divider");

        // Setup: divider 3 (4 cycles/bit), disabled, watermark 4
        bus_write(5'h18, 32'd3); bitlen = 4; nstop = 1;
        bus_write(5'h08, 32'h0004_0000);
        expect_reg(5'h14, 32'h1, "R7 pending below watermark");
        bus_write(5'h10, 32'h1);
        @(negedge clk);
        check(irq == 1'b1, "R8 irq set", irq, 1);
        bus_write(5'h14, 32'h0);
        expect_reg(5'h14, 32'h1, "R7 pending read-only");

        // Fill while disabled
        send_byte(8'h00, 1); send_byte(8'hFF, 1); send_byte(8'hA5, 1);
        expect_reg(5'h14, 32'h1, "R7 occupancy 3 below 4");
        send_byte(8'h5A, 1);
        expect_reg(5'h14, 32'h0, "R7 occupancy 4 not below 4");
        @(negedge clk);
        check(irq == 1'b0, "R8 irq clear", irq, 0);
        send_byte(8'h01, 1); send_byte(8'h80, 1); send_byte(8'h3C, 1);
        expect_reg(5'h00, 32'h0, "R2 not full at 7");
        send_byte(8'hC3, 1);
        expect_reg(5'h00, 32'h8000_0000, "R3 full flag");
        send_byte(8'hEE, 0);
        repeat (100) @(posedge clk);
        @(negedge clk);
        check(txd == 1'b1, "R5 disabled line high", txd, 1);
        check(frames == 0, "R5 no frames while disabled", frames, 0);

        // Enable, one stop bit, back-to-back burst of 8
        last_st = -1;
        bus_write(5'h08, 32'h0004_0001);
        repeat (8 * 10 * 4 + 60) @(posedge clk);
        check(frames == 8, "R3 eight frames, ninth dropped", frames, 8);
        check(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
        expect_reg(5'h00, 32'h0, "R2 data reg after drain");
        @(negedge clk);
        check(irq == 1'b1, "R8 irq after drain", irq, 1);

        // Two stop bits, divider 7 (8 cycles/bit)
        bus_write(5'h08, 32'h0004_0000);
        bus_write(5'h18, 32'd7); bitlen = 8; nstop = 2;
        last_st = -1;
        bus_write(5'h08, 32'h0004_0003);
        send_byte(8'h96, 1); send_byte(8'h0F, 1); send_byte(8'hF0, 1);
        repeat (3 * 11 * 8 + 60) @(posedge clk);
        check(frames == 11, "R6 two-stop frames", frames, 11);

        // Disable with data present, then re-enable
        bus_write(5'h08, 32'h0000_0002);
        last_st = -1;
        send_byte(8'h69, 1); send_byte(8'h24, 1);
        f0 = frames;
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(frames == f0 && txd == 1'b1, "R5 held while disabled", frames, f0);
        bus_write(5'h08, 32'h0000_0003);
        repeat (2 * 11 * 8 + 60) @(posedge clk);
        check(frames == f0 + 2, "R5 held bytes sent", frames, f0 + 2);
        check(exp_q.size() == 0, "R4 queue empty at end", exp_q.size(), 0);
        bus_read(5'h08, v);
        check(v == 32'h3, "R6 ctrl readback", v, 32'h3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule